// File: doc/BRIEF.md
# Node State Register with Cycle-Master Control

This block holds the three writable flags of a serial-bus node's STATE register: the dreq flag, the cycle-master flag (cmstr) and the abdicate flag. Software or a bus agent changes them with bit-set and bit-clear strobes that carry a 32-bit data word. The block also presents a fixed node-capabilities word. It drives a cycle-master enable level that tells the link layer whether to generate cycle-start packets.

The block applies the bus-reset rules through a remembered "was root" flag. Every reset clears abdicate. A node that has lost root status drops cmstr. A node that has just become root takes cmstr, and the enable, from its cycle-master capability. A node that stays root keeps cmstr as it was. The enable output is gated by the current root level, so cycle starts stop at once whenever the node is not root.

Top module: `node_state_reg`

## Requirements
- R1: A set or clear write changes only bit 8 (cmstr), bit 10 (abdicate) and bit 12 (dreq) of `state_word`. Every other bit of the write data is ignored, and every other bit of `state_word` reads 0.
- R2: A set write (`set_stb`) ORs the masked write data into the register.
- R3: A clear write (`clr_stb`) clears every masked bit that is 1 in the write data. When both strobes arrive in the same cycle, the clear wins for any bit named by both.
- R4: A set write with bit 8 while `is_root` is high turns the internal enable on. A clear write with bit 8 while `is_root` is high turns it off. When clear and set both name bit 8, the enable ends off. A write while `is_root` is low leaves the enable untouched.
- R5: Every bus reset clears abdicate and leaves dreq unchanged.
- R6: A bus reset while `is_root` is low clears was_root and cmstr. It does not turn the internal enable off, so the enable reappears if `is_root` later returns high.
- R7: A bus reset while `is_root` is high and was_root is false sets was_root. It then sets cmstr and the enable when `cm_capable` is high, or clears both when `cm_capable` is low.
- R8: A bus reset while `is_root` is high and was_root is true leaves cmstr and the enable unchanged.
- R9: After `rst_n` is low, `state_word` is 0, the enable is off and was_root is false.
- R10: `caps_word` always reads 32'h000083C0.
- R11: `cm_enable` is low whenever `is_root` is low. Otherwise it shows the internal enable.
- R12: A set or clear strobe in the same cycle as `bus_reset` is ignored. Only the bus-reset rules apply in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low initialisation |
| set_stb | input | 1 | Bit-set write strobe |
| clr_stb | input | 1 | Bit-clear write strobe |
| wdata | input | 32 | Write data word |
| bus_reset | input | 1 | One-cycle bus-reset pulse |
| is_root | input | 1 | Node is currently root (level) |
| cm_capable | input | 1 | Node can act as cycle master (level) |
| state_word | output | 32 | STATE register value |
| caps_word | output | 32 | Constant node-capabilities word |
| cm_enable | output | 1 | Cycle-start generation enable |

## Verification
Writes and bus resets are registered, so their effect on `state_word` and on the internal enable appears one clock after the edge that samples the strobe. The bench drives a step, waits one rising edge, then samples a few nanoseconds later, well before the next edge. `cm_enable` also follows `is_root` combinationally in the same cycle. For that reason, each vector holds its `is_root` value through its check, and the idle-cycle vectors confirm that the enable reappears once root returns. `caps_word` is constant and is checked both right after reset and later in the run.

// File: rtl/node_state_reg.sv
module node_state_reg #(
  parameter logic [31:0] CAPS = 32'h0000_83C0,
  parameter int unsigned CMSTR_BIT = 8,
  parameter int unsigned ABDIC_BIT = 10,
  parameter int unsigned DREQ_BIT  = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        set_stb,
  input  logic        clr_stb,
  input  logic [31:0] wdata,
  input  logic        bus_reset,
  input  logic        is_root,
  input  logic        cm_capable,
  output logic [31:0] state_word,
  output logic [31:0] caps_word,
  output logic        cm_enable
);

  logic cmstr_q, abdic_q, dreq_q, was_root_q, en_q;
  logic set_c, clr_c, set_a, clr_a, set_d, clr_d;

  assign set_c = set_stb & wdata[CMSTR_BIT];
  assign clr_c = clr_stb & wdata[CMSTR_BIT];
  assign set_a = set_stb & wdata[ABDIC_BIT];
  assign clr_a = clr_stb & wdata[ABDIC_BIT];
  assign set_d = set_stb & wdata[DREQ_BIT];
  assign clr_d = clr_stb & wdata[DREQ_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmstr_q    <= 1'b0;
      abdic_q    <= 1'b0;
      dreq_q     <= 1'b0;
      was_root_q <= 1'b0;
      en_q       <= 1'b0;
    end else if (bus_reset) begin
      abdic_q <= 1'b0;
      if (!is_root) begin
        was_root_q <= 1'b0;
        cmstr_q    <= 1'b0;
      end else if (!was_root_q) begin
        was_root_q <= 1'b1;
        cmstr_q    <= cm_capable;
        en_q       <= cm_capable;
      end
    end else begin
      cmstr_q <= (cmstr_q | set_c) & ~clr_c;
      abdic_q <= (abdic_q | set_a) & ~clr_a;
      dreq_q  <= (dreq_q  | set_d) & ~clr_d;
      if (is_root && clr_c)      en_q <= 1'b0;
      else if (is_root && set_c) en_q <= 1'b1;
    end
  end

  always_comb begin
    state_word            = '0;
    state_word[CMSTR_BIT] = cmstr_q;
    state_word[ABDIC_BIT] = abdic_q;
    state_word[DREQ_BIT]  = dreq_q;
  end

  assign caps_word = CAPS;
  assign cm_enable = en_q & is_root;

  p_reset_abdicate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> !state_word[ABDIC_BIT] && $stable(state_word[DREQ_BIT]));

  p_nonroot_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset && !is_root |=> !state_word[CMSTR_BIT] && !was_root_q && $stable(en_q));

  p_new_root_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset && is_root && !was_root_q |=>
      was_root_q && state_word[CMSTR_BIT] == $past(cm_capable) && en_q == $past(cm_capable));

  p_old_root_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset && is_root && was_root_q |=> $stable(state_word[CMSTR_BIT]) && $stable(en_q));

  p_root_set_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_reset && set_stb && !clr_stb && wdata[CMSTR_BIT] && is_root |=> en_q);

  p_root_clr_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_reset && clr_stb && wdata[CMSTR_BIT] && is_root |=> !en_q);

  p_write_during_reset_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset && set_stb |=> !state_word[ABDIC_BIT]);

endmodule

// File: tb/node_state_reg_test.sv
module node_state_reg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        set_stb = 1'b0, clr_stb = 1'b0, bus_reset = 1'b0;
  logic        is_root = 1'b0, cm_capable = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] state_word, caps_word;
  logic        cm_enable;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  node_state_reg uut (
    .clk(clk), .rst_n(rst_n), .set_stb(set_stb), .clr_stb(clr_stb),
    .wdata(wdata), .bus_reset(bus_reset), .is_root(is_root),
    .cm_capable(cm_capable), .state_word(state_word),
    .caps_word(caps_word), .cm_enable(cm_enable)
  );

  // {set, clr, brst, root, cap, wdata, exp_state, exp_en}
  localparam int NV = 17;
  localparam logic [69:0] VEC [NV] = '{
    {5'b10000, 32'hFFFF_FFFF, 32'h0000_1500, 1'b0}, // R1 mask, not root
    {5'b01000, 32'h0000_0400, 32'h0000_1100, 1'b0}, // R3 clear
    {5'b10010, 32'h0000_0100, 32'h0000_1100, 1'b1}, // R4 set as root
    {5'b00000, 32'h0000_0000, 32'h0000_1100, 1'b0}, // R11 gated
    {5'b00010, 32'h0000_0000, 32'h0000_1100, 1'b1}, // R11 back
    {5'b01010, 32'h0000_0100, 32'h0000_1000, 1'b0}, // R4 clear as root
    {5'b10010, 32'h0000_0400, 32'h0000_1400, 1'b0}, // R2 set OR
    {5'b00111, 32'h0000_0000, 32'h0000_1100, 1'b1}, // R7 new root capable, R5
    {5'b10010, 32'h0000_0400, 32'h0000_1500, 1'b1}, // R2
    {5'b00110, 32'h0000_0000, 32'h0000_1100, 1'b1}, // R8 old root, R5
    {5'b00100, 32'h0000_0000, 32'h0000_1000, 1'b0}, // R6 non-root reset
    {5'b00010, 32'h0000_0000, 32'h0000_1000, 1'b1}, // R6 enable kept
    {5'b00110, 32'h0000_0000, 32'h0000_1000, 1'b0}, // R7 not capable
    {5'b00100, 32'h0000_0000, 32'h0000_1000, 1'b0}, // R6
    {5'b10111, 32'h0000_0400, 32'h0000_1100, 1'b1}, // R12 write ignored
    {5'b11010, 32'h0000_0100, 32'h0000_1000, 1'b0}, // R3/R4 clear wins
    {5'b01000, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0}  // R3 clear all
  };

  task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check32("R9 state", state_word, 32'h0);
    check32("R9 enable", {31'b0, cm_enable}, 32'h0);
    check32("R10 caps", caps_word, 32'h0000_83C0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      {set_stb, clr_stb, bus_reset, is_root, cm_capable} = VEC[i][69:65];
      wdata = VEC[i][64:33];
      @(posedge clk);
      #2;
      set_stb = 1'b0; clr_stb = 1'b0; bus_reset = 1'b0;
      check32($sformatf("R1-R12 vector %0d state", i), state_word, VEC[i][32:1]);
      check32($sformatf("R4/R11 vector %0d enable", i), {31'b0, cm_enable}, {31'b0, VEC[i][0]});
      @(negedge clk);
    end

    check32("R10 caps later", caps_word, 32'h0000_83C0);

    // R9: re-initialisation clears was_root and state
    is_root = 1'b1; cm_capable = 1'b1;
    set_stb = 1'b1; wdata = 32'h0000_1500;
    @(negedge clk);
    set_stb = 1'b0;
    check32("R4 pre-reset enable", {31'b0, cm_enable}, 32'h1);
    rst_n = 1'b0;
    #2;
    check32("R9 async state", state_word, 32'h0);
    check32("R9 async enable", {31'b0, cm_enable}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    bus_reset = 1'b1;
    @(posedge clk);
    #2;
    bus_reset = 1'b0;
    check32("R9/R7 was_root cleared by reset", state_word, 32'h0000_0100);
    check32("R7 enable after new root", {31'b0, cm_enable}, 32'h1);

    // R4: set while not root leaves enable untouched
    @(negedge clk);
    clr_stb = 1'b1; wdata = 32'h100; is_root = 1'b1;
    @(negedge clk);
    clr_stb = 1'b0; is_root = 1'b0;
    set_stb = 1'b1; wdata = 32'h100;
    @(negedge clk);
    set_stb = 1'b0; is_root = 1'b1;
    #2;
    check32("R4 non-root set keeps enable off", {31'b0, cm_enable}, 32'h0);
    check32("R2 cmstr set while not root", state_word, 32'h0000_0100);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule